// File: doc/BRIEF.md
# Integer ALU with Status Flag Register

This block is a clocked integer arithmetic and logic unit. It has a parameterised data width (32 bits by default) and keeps six status flags in a register. Each accepted operation takes two operands and a 3-bit operation code. One clock edge later, the block presents the result and the updated flags. The flags stay unchanged until the next accepted operation or a direct software write.

Add-with-carry and subtract-with-borrow take their incoming carry from the carry flag already held in the register. This lets wide arithmetic be chained one word at a time.

Software can set or clear any chosen subset of flag bits through a masked write port.

Operand input follows a stream rule with no back-pressure. There is no ready signal: every cycle in which `op_valid` is high is an accepted operation. The result side raises `res_valid` for exactly one cycle per accepted operation. The downstream consumer must take the result in that cycle, because it is held but not re-announced.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `res_data` is zero, `flags` is zero and `res_valid` is low.
- R2: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 and, 5 or, 6 xor. The result of an operation accepted at a clock edge appears on `res_data` after that edge, and `res_valid` is high for that one cycle.
- R3: The flags are laid out as bit 0 carry, bit 1 parity, bit 2 auxiliary, bit 3 zero, bit 4 sign, bit 5 overflow.
  - For codes 0 and 1, carry is the carry out of the top bit.
  - For codes 2 and 3, carry is set when the unsigned first operand is smaller than the second operand plus the borrow-in.
  - Codes 1 and 3 use the stored carry (bit 0) as carry or borrow in. Codes 0 and 2 ignore it.
- R4: Overflow (bit 5) is set when the signed two's-complement result of an add or subtract lies outside the representable range.
- R5: Sign (bit 4) equals the top bit of the result. Zero (bit 3) is set exactly when every result bit is zero.
- R6: Auxiliary (bit 2) is set when an add carries, or a subtract borrows, from bit 3 into bit 4.
- R7: Parity (bit 1) is set when bits 7..0 of the result hold an even number of ones. Higher bits do not affect it.
- R8: Codes 4, 5 and 6 clear carry, overflow and auxiliary, whatever their earlier values.
- R9: With `op_valid` low, or with code 7, the result and flags keep their values and `res_valid` is low in the following cycle.
- R10: In a cycle where `flag_wr_mask` bit i is high, flag bit i takes `flag_wr_data` bit i at the clock edge. This holds even when an operation is accepted in the same cycle. Flag bits whose mask bit is low are not changed by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe, accepted every cycle it is high |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 32 | First operand (minuend for subtraction) |
| opnd_b | input | 32 | Second operand |
| flag_wr_mask | input | 6 | Per-bit enable for a direct flag write |
| flag_wr_data | input | 6 | Values for the enabled flag bits |
| res_data | output | 32 | Registered result |
| res_valid | output | 1 | One-cycle pulse announcing a new result |
| flags | output | 6 | Status flag register |

## Verification
The bench drives signed overflow in both directions and wraps to zero from the all-ones word. It also probes the borrow case where the operands are equal but the borrow-in is set. A design that let the stored carry leak into plain add or subtract, or that compared without the borrow, would give a wrong carry and result.

The parity cases use bytes whose upper bits would flip a full-word parity. A word-wide parity, or an auxiliary flag taken from the wrong bit, would therefore show up.

Preset carries before the logical operations catch a design that leaves carry set. A same-cycle masked write during an overflowing add catches write precedence given to the ALU. Code 7 and idle cycles catch a flag register that updates without a legal strobe.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int NUM_FLAGS = 6;
  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_RSV = 3'd7
  } op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  function automatic logic op_is_logic(op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_sub(op_e op);
    return (op == OP_SUB) || (op == OP_SBB);
  endfunction

  function automatic logic op_uses_cin(op_e op);
    return (op == OP_ADC) || (op == OP_SBB);
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cry,
  output logic         ovf,
  output logic         aux,
  output logic         legal
);
  localparam int MSB = W - 1;
  localparam int NIB = 4;

  logic         cin_eff;
  logic [W:0]   sum_ext;
  logic [W:0]   dif_ext;
  logic [W-1:0] logic_res;

  assign cin_eff = op_uses_cin(op) ? cin : 1'b0;
  assign sum_ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin_eff};
  assign dif_ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin_eff};

  always_comb begin
    unique case (op)
      OP_AND:  logic_res = a & b;
      OP_OR:   logic_res = a | b;
      default: logic_res = a ^ b;
    endcase
  end

  always_comb begin
    legal = (op != OP_RSV);
    res   = logic_res;
    cry   = 1'b0;
    ovf   = 1'b0;
    aux   = 1'b0;
    if (op_is_sub(op)) begin
      res = dif_ext[W-1:0];
      cry = dif_ext[W];
      ovf = (a[MSB] != b[MSB]) && (dif_ext[MSB] != a[MSB]);
      aux = a[NIB] ^ b[NIB] ^ dif_ext[NIB];
    end else if (!op_is_logic(op) && legal) begin
      res = sum_ext[W-1:0];
      cry = sum_ext[W];
      ovf = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
      aux = a[NIB] ^ b[NIB] ^ sum_ext[NIB];
    end
  end

  always_comb begin
    if (op_is_logic(op))
      assert_logic_no_carry_R8: assert (!cry && !ovf && !aux);
  end

endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval #(
  parameter int W        = 32,
  parameter int PAR_BITS = 8
) (
  input  logic [W-1:0] res,
  output logic         sgn,
  output logic         zro,
  output logic         par
);
  logic [PAR_BITS-1:0] par_chain;

  genvar gi;
  generate
    for (gi = 0; gi < PAR_BITS; gi++) begin : g_par
      if (gi == 0) begin : g_first
        assign par_chain[gi] = res[gi];
      end else begin : g_rest
        assign par_chain[gi] = par_chain[gi-1] ^ res[gi];
      end
    end
  endgenerate

  assign sgn = res[W-1];
  assign zro = (res == '0);
  assign par = ~par_chain[PAR_BITS-1];

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
#(
  parameter int NF = NUM_FLAGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [NF-1:0] alu_flags,
  input  logic [NF-1:0] wr_mask,
  input  logic [NF-1:0] wr_data,
  output logic [NF-1:0] flags_q
);
  logic [NF-1:0] base;
  logic [NF-1:0] nxt;

  assign base = upd_en ? alu_flags : flags_q;

  genvar gi;
  generate
    for (gi = 0; gi < NF; gi++) begin : g_bit
      assign nxt[gi] = wr_mask[gi] ? wr_data[gi] : base[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= nxt;
  end

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask != '0) |=> (((flags_q ^ $past(wr_data)) & $past(wr_mask)) == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && wr_mask == '0) |=> $stable(flags_q));

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W        = 32,
  parameter int PAR_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [2:0]           op_sel,
  input  logic [W-1:0]         opnd_a,
  input  logic [W-1:0]         opnd_b,
  input  logic [NUM_FLAGS-1:0] flag_wr_mask,
  input  logic [NUM_FLAGS-1:0] flag_wr_data,
  output logic [W-1:0]         res_data,
  output logic                 res_valid,
  output logic [NUM_FLAGS-1:0] flags
);
  op_e          op;
  logic [W-1:0] alu_res;
  logic         a_cry, a_ovf, a_aux, a_legal;
  logic         e_sgn, e_zro, e_par;
  logic         upd_en;
  flags_t       alu_fl;

  assign op = op_e'(op_sel);

  alu_arith #(.W(W)) u_arith (
    .op    (op),
    .a     (opnd_a),
    .b     (opnd_b),
    .cin   (flags[FL_CF]),
    .res   (alu_res),
    .cry   (a_cry),
    .ovf   (a_ovf),
    .aux   (a_aux),
    .legal (a_legal)
  );

  alu_flag_eval #(.W(W), .PAR_BITS(PAR_BITS)) u_eval (
    .res (alu_res),
    .sgn (e_sgn),
    .zro (e_zro),
    .par (e_par)
  );

  assign upd_en = op_valid && a_legal;

  always_comb begin
    alu_fl.ovf = a_ovf;
    alu_fl.sgn = e_sgn;
    alu_fl.zro = e_zro;
    alu_fl.aux = a_aux;
    alu_fl.par = e_par;
    alu_fl.cry = a_cry;
  end

  alu_flag_reg #(.NF(NUM_FLAGS)) u_freg (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .alu_flags (alu_fl),
    .wr_mask   (flag_wr_mask),
    .wr_data   (flag_wr_data),
    .flags_q   (flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= upd_en;
      if (upd_en) res_data <= alu_res;
    end
  end

  assert_sign_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(flag_wr_mask[FL_SF])) |-> (flags[FL_SF] == res_data[W-1]));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(flag_wr_mask[FL_ZF])) |-> (flags[FL_ZF] == (res_data == '0)));

  assert_low_byte_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(flag_wr_mask[FL_PF])) |-> (flags[FL_PF] == ~^res_data[PAR_BITS-1:0]));

  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel inside {3'd4, 3'd5, 3'd6} && !flag_wr_mask[FL_CF]
     && !flag_wr_mask[FL_OF] && !flag_wr_mask[FL_AF])
    |=> (!flags[FL_CF] && !flags[FL_OF] && !flags[FL_AF]));

  assert_reserved_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_sel == 3'd7) |=> (!res_valid && $stable(res_data)));

endmodule

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  // {op[2:0], a[31:0], b[31:0], preset_carry, exp_res[31:0], exp_flags[5:0]}
  // flags = {OF,SF,ZF,AF,PF,CF}
  localparam logic [105:0] VECS [0:NV-1] = '{
    {3'd0, 32'h00000001, 32'h00000001, 1'b0, 32'h00000002, 6'h00}, // R2 plain add
    {3'd0, 32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 6'h0F}, // R3 R5 R6 wrap
    {3'd0, 32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000, 6'h36}, // R4 pos overflow
    {3'd1, 32'h00000005, 32'h00000003, 1'b1, 32'h00000009, 6'h02}, // R3 carry in
    {3'd2, 32'h00000003, 32'h00000005, 1'b0, 32'hFFFFFFFE, 6'h15}, // R3 borrow
    {3'd2, 32'h80000000, 32'h00000001, 1'b0, 32'h7FFFFFFF, 6'h26}, // R4 neg overflow
    {3'd3, 32'h00000010, 32'h00000000, 1'b1, 32'h0000000F, 6'h06}, // R6 nibble borrow
    {3'd3, 32'h00000005, 32'h00000005, 1'b1, 32'hFFFFFFFF, 6'h17}, // R3 equal+borrow
    {3'd2, 32'h00000005, 32'h00000005, 1'b1, 32'h00000000, 6'h0A}, // R3 SUB ignores carry
    {3'd4, 32'hF0F0F0F0, 32'h0FFFFFF0, 1'b1, 32'h00F0F0F0, 6'h02}, // R8 and
    {3'd5, 32'h80000000, 32'h00000003, 1'b1, 32'h80000003, 6'h12}, // R8 or
    {3'd6, 32'hAAAAAAAA, 32'hAAAAAAAA, 1'b1, 32'h00000000, 6'h0A}, // R8 xor
    {3'd0, 32'h0000000F, 32'h00000001, 1'b1, 32'h00000010, 6'h04}, // R6 ADD ignores carry
    {3'd1, 32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000, 6'h0F}, // R3 carry chain
    {3'd4, 32'hFFFFFF7F, 32'hFFFFFFFF, 1'b0, 32'hFFFFFF7F, 6'h10}  // R7 odd low byte
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [5:0]  flag_wr_mask = '0;
  logic [5:0]  flag_wr_data = '0;
  logic [31:0] res_data;
  logic        res_valid;
  logic [5:0]  flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  alu_flag_unit uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_sel       (op_sel),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .flag_wr_mask (flag_wr_mask),
    .flag_wr_data (flag_wr_data),
    .res_data     (res_data),
    .res_valid    (res_valid),
    .flags        (flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_flags(logic [5:0] m, logic [5:0] d);
    flag_wr_mask = m;
    flag_wr_data = d;
    @(negedge clk);
    flag_wr_mask = '0;
    flag_wr_data = '0;
  endtask

  task automatic issue(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                       logic [5:0] m, logic [5:0] d);
    op_valid = 1'b1;
    op_sel = op;
    opnd_a = a;
    opnd_b = b;
    flag_wr_mask = m;
    flag_wr_data = d;
    @(negedge clk);
    op_valid = 1'b0;
    flag_wr_mask = '0;
    flag_wr_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep_res;
    logic [5:0]  keep_fl;
    repeat (3) @(negedge clk);
    check("R1 reset result", res_data, 0);
    check("R1 reset flags", flags, 0);
    check("R1 reset valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle flags", flags, 0);

    for (int i = 0; i < NV; i++) begin
      write_flags(6'b000001, {5'b0, VECS[i][38]});
      issue(VECS[i][105:103], VECS[i][102:71], VECS[i][70:39], 6'b0, 6'b0);
      check($sformatf("R2 result vec%0d", i), res_data, VECS[i][37:6]);
      check($sformatf("R3/R4/R5/R6/R7/R8 flags vec%0d", i), flags, VECS[i][5:0]);
      check($sformatf("R2 valid vec%0d", i), res_valid, 1);
    end

    // R9 idle cycles hold everything
    keep_res = res_data;
    keep_fl  = flags;
    repeat (3) @(negedge clk);
    check("R9 idle result", res_data, keep_res);
    check("R9 idle flags", flags, keep_fl);
    check("R9 idle valid", res_valid, 0);

    // R9 reserved code 7 is ignored
    issue(3'd7, 32'h0, 32'h0, 6'b0, 6'b0);
    check("R9 code7 result", res_data, keep_res);
    check("R9 code7 flags", flags, keep_fl);
    check("R9 code7 valid", res_valid, 0);

    // R10 write beats ALU for masked bit only (OF forced to 0)
    write_flags(6'b111111, 6'b000000);
    issue(3'd0, 32'h7FFFFFFF, 32'h00000001, 6'b100000, 6'b000000);
    check("R10 same-cycle result", res_data, 32'h80000000);
    check("R10 same-cycle flags", flags, 6'h16);
    // R10 lone write touches only ZF
    write_flags(6'b001000, 6'b111111);
    check("R10 masked write flags", flags, 6'h1E);
    check("R10 masked write result", res_data, 32'h80000000);
    check("R10 masked write valid", res_valid, 0);

    // R1 reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rerun result", res_data, 0);
    check("R1 rerun flags", flags, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule